// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six interrupt sources into a request register, qualifies them with per-source enables and a global enable, and picks one winner with a priority order that software can rotate. Three external pins go through a synchronizer and an edge detector. A falling edge on any of the three pins raises a request. A rising edge on the middle pin raises a fourth request. Two timer end-of-count pulses raise the remaining two requests.

The core sees a registered request flag, the winning source number and the program-memory address of that source's vector. When the core takes the interrupt it pulses the acknowledge input. On that edge the block clears the winning request and the global enable, so no further interrupt is offered until software enables them again. The request, enable and priority registers sit on a small synchronous register bus. Software can therefore poll pending requests with the global enable off and service them without vectoring.

Top module: `pvic_top`

## Requirements
- R1: After a synchronous reset, all six request bits, all enables and the priority field are 0, and `irq_valid_o` is 0.
- R2: Each pin is synchronized by two flops before edge detection. A falling edge on pin 0, 1 or 2 sets request bit 0, 1 or 2. A rising edge on pin 1 sets request bit 3. A rising edge on pin 0 or pin 2 sets nothing. A pin change settled before clock edge k is latched in the request register at edge k+2.
- R3: A one-cycle high on `tmr_eoc_i[0]` sets request bit 4, and on `tmr_eoc_i[1]` sets request bit 5, at the same edge.
- R4: The register bus has three registers. Address 0 holds the requests in bits 5:0. Address 1 holds the per-source enables in bits 5:0 and the global enable in bit 7. Address 2 holds the priority field in bits 2:0. Address 3 reads as 0. A write takes effect at the edge where `bus_wr_i` is high. `bus_rdata_o` shows the addressed register one edge after the address is presented.
- R5: A request bit stays set until it is cleared by a grant or by a bus write of 0. When a hardware event and a clear occur at the same edge, the event wins and the bit ends up set.
- R6: `irq_valid_o` is high exactly when the global enable is 1 and at least one request has its own enable set. It is registered, and it reflects the register values written at the same edge.
- R7: For a priority field p in 0..5, sources are ranked p, p+1, ... modulo 6, and the first enabled pending source in that ranking wins. Field values 6 and 7 behave as 0.
- R8: `irq_vec_o` equals 2 × `irq_id_o`, which is the address of the high byte of that source's 16-bit vector; the low byte is at the next address.
- R9: If `irq_ack_i` is high while `irq_valid_o` is high, that edge clears the request bit of `irq_id_o` and the global enable, so `irq_valid_o` is 0 afterwards. If `irq_ack_i` is high while `irq_valid_o` is low, nothing changes.
- R10: With the global enable at 0, requests still latch and read back on the bus, and `irq_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 3 | Asynchronous external interrupt pins |
| tmr_eoc_i | input | 2 | Timer end-of-count pulses (bit 0 → source 4, bit 1 → source 5) |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_valid_o | output | 1 | An enabled request is offered to the core |
| irq_id_o | output | 3 | Winning source number |
| irq_vec_o | output | 16 | Program-memory address of the winner's vector high byte |
| irq_ack_i | input | 1 | Core accepts the offered interrupt |

## Verification
The hardest case to reach from the ports is a hardware event landing on exactly the edge where the same request bit is cleared. The bench forces this by driving a timer pulse in the same cycle as a bus write of zero to the request register. It then reads back to confirm the event survived. The bench also exercises the pin path with levels held across the synchronizer long enough to settle. It includes a rising edge on a pin that must produce no request, and an acknowledge given while nothing is offered.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int N_SRC   = 6;
  localparam int N_PIN   = 3;
  localparam int ID_W    = 3;
  localparam int PRIO_W  = 3;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int GIE_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_REQ  = 2'd0,
    REG_MASK = 2'd1,
    REG_PRIO = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pvic_edge.sv
module pvic_edge #(
  parameter int N_PIN = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_PIN-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PIN-1:0] pin_i,
  output logic [N_PIN-1:0] fall_o,
  output logic [N_PIN-1:0] rise_o
);
  logic [N_PIN-1:0] stg_q [SYNC_STAGES];
  logic [N_PIN-1:0] prev_q;
  logic [N_PIN-1:0] cur;

  assign cur = stg_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= IDLE;
      prev_q <= IDLE;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= cur;
    end
  end

  assign fall_o = prev_q & ~cur;
  assign rise_o = ~prev_q & cur;

  for (genvar g = 0; g < N_PIN; g++) begin : g_chk
    AST_FALL_PULSE: assert property (@(posedge clk) disable iff (rst)
      fall_o[g] |=> !fall_o[g]) else $error("fall pulse longer than a cycle"); // R2
    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]) else $error("rise pulse longer than a cycle"); // R2
  end
endmodule

// File: rtl/pvic_resolve.sv
module pvic_resolve
  import pvic_pkg::*;
(
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              win_valid_o,
  output logic [ID_W-1:0]   win_id_o
);
  int start;

  always_comb begin
    start = (int'(prio_i) < N_SRC) ? int'(prio_i) : 0;
    win_valid_o = 1'b0;
    win_id_o    = '0;
    // walk from lowest rank to highest so the highest rank is assigned last
    for (int k = N_SRC - 1; k >= 0; k--) begin
      int idx;
      idx = (start + k) % N_SRC;
      if (pend_i[idx]) begin
        win_valid_o = 1'b1;
        win_id_o    = ID_W'(idx);
      end
    end
  end

  always_comb begin
    if (win_valid_o) begin
      AST_WIN_PENDING: assert (pend_i[win_id_o]) else $error("winner not pending"); // R7
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PIN-1:0]  ext_pin_i,
  input  logic [1:0]        tmr_eoc_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_valid_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i
);
  logic [N_PIN-1:0]  fall, rise;
  logic [N_SRC-1:0]  events;
  logic [N_SRC-1:0]  req_q, req_nxt, en_q, en_nxt;
  logic              gie_q, gie_nxt;
  logic [PRIO_W-1:0] prio_q, prio_nxt;
  logic              take, win_valid;
  logic [ID_W-1:0]   win_id;
  logic              wr_req, wr_mask, wr_prio;

  pvic_edge #(.N_PIN(N_PIN), .SYNC_STAGES(SYNC_STAGES), .IDLE('1)) u_edge (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i), .fall_o(fall), .rise_o(rise)
  );

  assign events  = {tmr_eoc_i[1], tmr_eoc_i[0], rise[1], fall[2], fall[1], fall[0]};
  assign take    = irq_ack_i & irq_valid_o;
  assign wr_req  = bus_wr_i && (bus_addr_i == REG_REQ);
  assign wr_mask = bus_wr_i && (bus_addr_i == REG_MASK);
  assign wr_prio = bus_wr_i && (bus_addr_i == REG_PRIO);

  always_comb begin
    req_nxt  = req_q;
    en_nxt   = en_q;
    gie_nxt  = gie_q;
    prio_nxt = prio_q;
    if (wr_req)  req_nxt = bus_wdata_i[N_SRC-1:0];
    if (wr_mask) begin
      en_nxt  = bus_wdata_i[N_SRC-1:0];
      gie_nxt = bus_wdata_i[GIE_BIT];
    end
    if (wr_prio) prio_nxt = bus_wdata_i[PRIO_W-1:0];
    if (take) begin
      req_nxt[irq_id_o] = 1'b0;
      gie_nxt = 1'b0;
    end
    req_nxt = req_nxt | events;
  end

  pvic_resolve u_resolve (
    .pend_i(req_nxt & en_nxt), .prio_i(prio_nxt),
    .win_valid_o(win_valid), .win_id_o(win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= '0;
      en_q        <= '0;
      gie_q       <= 1'b0;
      prio_q      <= '0;
      irq_valid_o <= 1'b0;
      irq_id_o    <= '0;
      irq_vec_o   <= '0;
      bus_rdata_o <= '0;
    end else begin
      req_q       <= req_nxt;
      en_q        <= en_nxt;
      gie_q       <= gie_nxt;
      prio_q      <= prio_nxt;
      irq_valid_o <= win_valid & gie_nxt;
      irq_id_o    <= win_id;
      irq_vec_o   <= VEC_W'({win_id, 1'b0});
      case (bus_addr_i)
        REG_REQ:  bus_rdata_o <= DATA_W'(req_q);
        REG_MASK: bus_rdata_o <= {gie_q, {(DATA_W-1-N_SRC){1'b0}}, en_q};
        REG_PRIO: bus_rdata_o <= DATA_W'(prio_q);
        default:  bus_rdata_o <= '0;
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_q == '0 && !gie_q && !irq_valid_o)) else $error("reset state"); // R1
  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (rst)
    tmr_eoc_i[0] |=> req_q[4]) else $error("timer request lost"); // R3
  AST_VALID_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (gie_q && req_q[irq_id_o] && en_q[irq_id_o])) else $error("offer without pending"); // R6
  AST_GRANT_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
    take |=> (!gie_q && !irq_valid_o)) else $error("grant kept enable"); // R9
  AST_GRANT_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
    (take && !events[irq_id_o] && !wr_req) |=> !req_q[$past(irq_id_o)]) else $error("grant kept request"); // R9
endmodule

// File: tb/test_pvic_top.sv
module test_pvic_top;
  import pvic_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  ext_pin;
  logic [1:0]  tmr_eoc;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_valid;
  logic [2:0]  irq_id;
  logic [15:0] irq_vec;
  logic        irq_ack;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pvic_top i_pvic_top (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .tmr_eoc_i(tmr_eoc),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_valid_o(irq_valid), .irq_id_o(irq_id),
    .irq_vec_o(irq_vec), .irq_ack_i(irq_ack)
  );

  // {requests[5:0], mask reg[7:0], priority[2:0], expect valid, expect id[2:0]}
  localparam logic [20:0] TBL [10] = '{
    {6'h01, 8'hBF, 3'd0, 1'b1, 3'd0},
    {6'h3F, 8'hBF, 3'd3, 1'b1, 3'd3},
    {6'h3F, 8'hBF, 3'd5, 1'b1, 3'd5},
    {6'h26, 8'hBF, 3'd3, 1'b1, 3'd5},
    {6'h26, 8'h9B, 3'd3, 1'b1, 3'd1},
    {6'h3F, 8'h3F, 3'd0, 1'b0, 3'd0},
    {6'h3F, 8'hBF, 3'd7, 1'b1, 3'd0},
    {6'h10, 8'hBF, 3'd6, 1'b1, 3'd4},
    {6'h3F, 8'h80, 3'd0, 1'b0, 3'd0},
    {6'h0C, 8'hBF, 3'd4, 1'b1, 3'd2}
  };

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ext_pin = 3'b111; tmr_eoc = 2'b00;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00; irq_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [5:0] t_req; logic [7:0] t_mask; logic [2:0] t_prio;
    logic t_v; logic [2:0] t_id;

    // table of request/enable/priority patterns
    for (int i = 0; i < 10; i++) begin
      {t_req, t_mask, t_prio, t_v, t_id} = TBL[i];
      do_reset();
      bus_write(REG_REQ, {2'b00, t_req});
      bus_write(REG_PRIO, {5'b0, t_prio});
      bus_write(REG_MASK, t_mask);
      chk($sformatf("R6/R7 row %0d valid", i), irq_valid, t_v);
      if (t_v) begin
        chk($sformatf("R7 row %0d id", i), irq_id, t_id);
        chk($sformatf("R8 row %0d vector", i), irq_vec, 2 * t_id);
      end
    end

    // R1 reset state
    do_reset();
    chk("R1 valid", irq_valid, 0);
    bus_read(REG_REQ, rd);  chk("R1 req", rd, 8'h00);
    bus_read(REG_MASK, rd); chk("R1 mask", rd, 8'h00);
    bus_read(REG_PRIO, rd); chk("R1 prio", rd, 8'h00);

    // R4 readback
    bus_write(REG_MASK, 8'h95); bus_read(REG_MASK, rd); chk("R4 mask", rd, 8'h95);
    bus_write(REG_PRIO, 8'h05); bus_read(REG_PRIO, rd); chk("R4 prio", rd, 8'h05);
    bus_write(REG_REQ, 8'h2A);  bus_read(REG_REQ, rd);  chk("R4 req", rd, 8'h2A);
    bus_read(REG_NONE, rd); chk("R4 unused address", rd, 8'h00);

    // R2 pin edges, R10 polling with global enable off
    do_reset();
    bus_write(REG_MASK, 8'h3F);
    @(negedge clk); ext_pin = 3'b110;
    settle();
    bus_read(REG_REQ, rd); chk("R2 pin0 fall", rd, 8'h01);
    chk("R10 no offer while disabled", irq_valid, 0);
    bus_write(REG_REQ, 8'h00);
    @(negedge clk); ext_pin = 3'b100;
    settle();
    bus_read(REG_REQ, rd); chk("R2 pin1 fall", rd, 8'h02);
    @(negedge clk); ext_pin = 3'b110;
    settle();
    bus_read(REG_REQ, rd); chk("R2 pin1 rise", rd, 8'h0A);
    @(negedge clk); ext_pin = 3'b011;
    settle();
    bus_read(REG_REQ, rd); chk("R2 pin2 fall, pin0 rise ignored", rd, 8'h0E);

    // R3 timers
    bus_write(REG_REQ, 8'h00);
    @(negedge clk); tmr_eoc = 2'b10;
    @(negedge clk); tmr_eoc = 2'b00;
    bus_read(REG_REQ, rd); chk("R3 timer1", rd, 8'h20);

    // R5 event beats a simultaneous clear, then holds
    @(negedge clk);
    bus_addr = REG_REQ; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_eoc = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; tmr_eoc = 2'b00;
    bus_read(REG_REQ, rd); chk("R5 event wins over clear", rd, 8'h10);
    settle();
    bus_read(REG_REQ, rd); chk("R5 request held", rd, 8'h10);
    chk("R10 still no offer", irq_valid, 0);

    // R9 grant
    do_reset();
    bus_write(REG_REQ, 8'h05);
    bus_write(REG_MASK, 8'hBF);
    chk("R6 offer", irq_valid, 1);
    chk("R7 first winner", irq_id, 0);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R9 offer dropped", irq_valid, 0);
    bus_read(REG_REQ, rd);  chk("R9 request cleared", rd, 8'h04);
    bus_read(REG_MASK, rd); chk("R9 global enable cleared", rd, 8'h3F);
    bus_write(REG_MASK, 8'hBF);
    chk("R9 re-enabled offer", irq_valid, 1);
    chk("R8 second vector", irq_vec, 4);
    bus_write(REG_MASK, 8'h3F);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    bus_read(REG_REQ, rd);  chk("R9 ack ignored when idle", rd, 8'h04);
    bus_read(REG_MASK, rd); chk("R9 mask kept when idle", rd, 8'h3F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule